// File: doc/BRIEF.md
# Two-Mode Cartridge Bank Controller

This block sits between a CPU with a 16-bit address bus and a cartridge that holds a ROM larger than the CPU can address directly, plus an external RAM that is split into banks. The block turns CPU addresses into physical ROM and RAM addresses. CPU writes that land in the ROM address space never reach the ROM. The block decodes them into four control registers: a RAM enable, a 5-bit ROM bank number, a 2-bit secondary bank number and a banking-mode bit.

The mode bit is kept as a two-state machine, SIMPLE and ADVANCED. In SIMPLE the low ROM window (0x0000–0x3FFF) always shows physical bank 0, and RAM accesses always use RAM bank 0. In ADVANCED the secondary bank also selects the bank seen in the low ROM window and the RAM bank. In both states the secondary bank forms the upper bits of the bank shown in the switchable upper window (0x4000–0x7FFF). Each computed ROM bank is cut down to the number of banks actually fitted, which is set by a parameter.

The ROM and RAM arrays are outside this block. RAM read data returns through the block, so a disabled RAM reads as 0xFF.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank register is 1, and the secondary bank, the mode and the RAM enable are 0. So a read at 0x4000+n gives ROM address 0x4000+n, and a read at 0xA000 returns 0xFF.
- R2: A write to 0x0000–0x1FFF enables RAM when data bits [3:0] equal 0xA, whatever the upper bits are. Any other low nibble disables RAM.
- R3: A write to 0x2000–0x3FFF loads the ROM bank register from data bits [4:0]. The value 0 in those bits is stored as 1, and bits [7:5] are ignored.
- R4: A write to 0x4000–0x5FFF loads the secondary bank from data bits [1:0].
- R5: A write to 0x6000–0x7FFF moves the mode machine to ADVANCED when data bit 0 is 1, and to SIMPLE when it is 0.
- R6: In SIMPLE, a read at 0x0000–0x3FFF gives ROM address equal to the CPU address.
- R7: In ADVANCED, a read at 0x0000–0x3FFF gives ROM address ((secondary << 5) mod ROM_BANKS) × 0x4000 + address[13:0].
- R8: A read at 0x4000–0x7FFF gives ROM address (((secondary << 5) | bank) mod ROM_BANKS) × 0x4000 + address[13:0], in either mode.
- R9: A read at 0xA000–0xBFFF asserts ram_cs and returns ram_rdata on cpu_rdata only while RAM is enabled. While RAM is disabled, ram_cs stays low and cpu_rdata is 0xFF.
- R10: ram_we is asserted only for a write to 0xA000–0xBFFF while RAM is enabled. Such a write changes no control register.
- R11: The RAM address is {RAM bank, address[12:0]}. The RAM bank is (secondary mod RAM_BANKS) in ADVANCED and 0 in SIMPLE.
- R12: Writes to 0x8000–0x9FFF and 0xC000–0xFFFF leave every control register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| ram_rdata | input | 8 | Data returned by the external RAM |
| rom_cs | output | 1 | ROM read select (read below 0x8000) |
| rom_addr | output | ROM_A_W | Physical ROM byte address |
| ram_cs | output | 1 | External RAM select |
| ram_we | output | 1 | External RAM write enable |
| ram_addr | output | RAM_A_W | Physical RAM byte address |
| ram_wdata | output | 8 | Data written to RAM |
| cpu_rdata | output | 8 | RAM read data, or 0xFF when RAM is disabled |

## Verification
The hardest case to reach is the one where masking to the fitted bank count changes the result. This happens when the secondary bank drives bits above the top of the ROM, in the upper window and, in ADVANCED, in the low window. The bench builds the block with half the default ROM. It then sweeps both modes, every secondary value and every 5-bit bank value, including 0 with non-zero upper data bits. For each combination it checks both ROM windows against the bank computed arithmetically from the written values.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int LO_W      = 5;
    localparam int SEC_W     = 2;
    localparam int FULL_W    = LO_W + SEC_W;
    localparam int WIN_W     = 14;
    localparam int RAM_OFF_W = 13;

    typedef enum logic [2:0] {
        RGN_ENABLE,
        RGN_BANK_LO,
        RGN_BANK_HI,
        RGN_MODE,
        RGN_RAM,
        RGN_NONE
    } rgn_e;

    typedef enum logic {
        MODE_SIMPLE,
        MODE_ADVANCED
    } bmode_e;

    function automatic rgn_e region_of(input logic [15:0] a);
        case (a[15:13])
            3'b000:  return RGN_ENABLE;
            3'b001:  return RGN_BANK_LO;
            3'b010:  return RGN_BANK_HI;
            3'b011:  return RGN_MODE;
            3'b101:  return RGN_RAM;
            default: return RGN_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
    import cbc_pkg::*;
(
    input  logic [15:0] addr,
    input  logic        wr,
    output logic        wr_enable,
    output logic        wr_bank_lo,
    output logic        wr_bank_hi,
    output logic        wr_mode,
    output logic        in_ram_win
);

    rgn_e rgn;

    assign rgn = region_of(addr);

    always_comb begin
        wr_enable  = 1'b0;
        wr_bank_lo = 1'b0;
        wr_bank_hi = 1'b0;
        wr_mode    = 1'b0;
        in_ram_win = 1'b0;
        unique case (rgn)
            RGN_ENABLE:  wr_enable  = wr;
            RGN_BANK_LO: wr_bank_lo = wr;
            RGN_BANK_HI: wr_bank_hi = wr;
            RGN_MODE:    wr_mode    = wr;
            RGN_RAM:     in_ram_win = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
    import cbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_enable,
    input  logic             wr_bank_lo,
    input  logic             wr_bank_hi,
    input  logic             wr_mode,
    input  logic [7:0]       wdata,
    output logic             ram_on,
    output logic [LO_W-1:0]  bank_lo,
    output logic [SEC_W-1:0] bank_sec,
    output logic             mode_adv
);

    bmode_e          state_q, state_d;
    logic            ram_on_q;
    logic [LO_W-1:0] bank_lo_q;
    logic [SEC_W-1:0] bank_sec_q;
    logic [LO_W-1:0] lo_in;

    // Mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_SIMPLE;
        else        state_q <= state_d;
    end

    // Mode transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SIMPLE:   if (wr_mode && wdata[0])  state_d = MODE_ADVANCED;
            MODE_ADVANCED: if (wr_mode && !wdata[0]) state_d = MODE_SIMPLE;
            default:       state_d = MODE_SIMPLE;
        endcase
    end

    // Mode outputs
    always_comb begin
        unique case (state_q)
            MODE_ADVANCED: mode_adv = 1'b1;
            default:       mode_adv = 1'b0;
        endcase
    end

    assign lo_in = (wdata[LO_W-1:0] == '0) ? LO_W'(1) : wdata[LO_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_on_q   <= 1'b0;
            bank_lo_q  <= LO_W'(1);
            bank_sec_q <= '0;
        end else begin
            if (wr_enable)  ram_on_q   <= (wdata[3:0] == 4'hA);
            if (wr_bank_lo) bank_lo_q  <= lo_in;
            if (wr_bank_hi) bank_sec_q <= wdata[SEC_W-1:0];
        end
    end

    assign ram_on   = ram_on_q;
    assign bank_lo  = bank_lo_q;
    assign bank_sec = bank_sec_q;

endmodule

// File: rtl/cbc_map.sv
module cbc_map
    import cbc_pkg::*;
#(
    parameter  int ROM_BANKS = 128,
    parameter  int RAM_BANKS = 4,
    localparam int BANK_W    = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
    localparam int RAMB_W    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
    localparam int ROM_A_W   = BANK_W + WIN_W,
    localparam int RAM_A_W   = RAMB_W + RAM_OFF_W
)(
    input  logic [15:0]        addr,
    input  logic [LO_W-1:0]    bank_lo,
    input  logic [SEC_W-1:0]   bank_sec,
    input  logic               mode_adv,
    output logic [ROM_A_W-1:0] rom_addr,
    output logic [RAM_A_W-1:0] ram_addr
);

    logic [FULL_W-1:0] full_up, full_zero;
    logic [BANK_W-1:0] bank_up, bank_zero, bank_sel;
    logic [RAMB_W-1:0] ram_bank;

    assign full_up   = {bank_sec, bank_lo};
    assign full_zero = {bank_sec, {LO_W{1'b0}}};

    // Cut the bank to the fitted ROM size (power of two)
    generate
        if (BANK_W <= FULL_W) begin : g_rom_trunc
            assign bank_up   = full_up[BANK_W-1:0];
            assign bank_zero = full_zero[BANK_W-1:0];
        end else begin : g_rom_ext
            assign bank_up   = {{(BANK_W-FULL_W){1'b0}}, full_up};
            assign bank_zero = {{(BANK_W-FULL_W){1'b0}}, full_zero};
        end

        if (RAM_BANKS <= 1) begin : g_ram_single
            assign ram_bank = '0;
        end else if (RAMB_W <= SEC_W) begin : g_ram_trunc
            assign ram_bank = mode_adv ? bank_sec[RAMB_W-1:0] : '0;
        end else begin : g_ram_ext
            assign ram_bank = mode_adv ? {{(RAMB_W-SEC_W){1'b0}}, bank_sec} : '0;
        end
    endgenerate

    always_comb begin
        if (addr[14])      bank_sel = bank_up;
        else if (mode_adv) bank_sel = bank_zero;
        else               bank_sel = '0;
    end

    assign rom_addr = {bank_sel, addr[WIN_W-1:0]};
    assign ram_addr = {ram_bank, addr[RAM_OFF_W-1:0]};

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter  int ROM_BANKS = 128,
    parameter  int RAM_BANKS = 4,
    localparam int BANK_W    = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
    localparam int RAMB_W    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
    localparam int ROM_A_W   = BANK_W + WIN_W,
    localparam int RAM_A_W   = RAMB_W + RAM_OFF_W
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic [7:0]         ram_rdata,
    output logic               rom_cs,
    output logic [ROM_A_W-1:0] rom_addr,
    output logic               ram_cs,
    output logic               ram_we,
    output logic [RAM_A_W-1:0] ram_addr,
    output logic [7:0]         ram_wdata,
    output logic [7:0]         cpu_rdata
);

    logic             wr_enable, wr_bank_lo, wr_bank_hi, wr_mode, in_ram_win;
    logic             ram_on, mode_adv;
    logic [LO_W-1:0]  bank_lo;
    logic [SEC_W-1:0] bank_sec;

    cbc_decode u_dec (
        .addr       (cpu_addr),
        .wr         (cpu_wr),
        .wr_enable  (wr_enable),
        .wr_bank_lo (wr_bank_lo),
        .wr_bank_hi (wr_bank_hi),
        .wr_mode    (wr_mode),
        .in_ram_win (in_ram_win)
    );

    cbc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_enable  (wr_enable),
        .wr_bank_lo (wr_bank_lo),
        .wr_bank_hi (wr_bank_hi),
        .wr_mode    (wr_mode),
        .wdata      (cpu_wdata),
        .ram_on     (ram_on),
        .bank_lo    (bank_lo),
        .bank_sec   (bank_sec),
        .mode_adv   (mode_adv)
    );

    cbc_map #(
        .ROM_BANKS (ROM_BANKS),
        .RAM_BANKS (RAM_BANKS)
    ) u_map (
        .addr     (cpu_addr),
        .bank_lo  (bank_lo),
        .bank_sec (bank_sec),
        .mode_adv (mode_adv),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr)
    );

    logic ram_rd_hit;

    assign ram_rd_hit = cpu_rd && in_ram_win && ram_on;
    assign rom_cs     = cpu_rd && !cpu_addr[15];
    assign ram_cs     = (cpu_rd || cpu_wr) && in_ram_win && ram_on;
    assign ram_we     = cpu_wr && in_ram_win && ram_on;
    assign ram_wdata  = cpu_wdata;
    assign cpu_rdata  = ram_rd_hit ? ram_rdata : 8'hFF;

endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
    parameter int ROM_A_W = 21
)(
    input logic               clk,
    input logic               rst_n,
    input logic [15:0]        cpu_addr,
    input logic [7:0]         cpu_wdata,
    input logic               cpu_wr,
    input logic               cpu_rd,
    input logic               ram_cs,
    input logic               ram_we,
    input logic [7:0]         cpu_rdata,
    input logic [ROM_A_W-1:0] rom_addr,
    input logic               ram_on,
    input logic               mode_adv,
    input logic [4:0]         bank_lo,
    input logic [1:0]         bank_sec
);

    // R9
    ram_off_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15:13] == 3'b101 && !ram_on) |-> (cpu_rdata == 8'hFF && !ram_cs));

    // R10
    ram_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cpu_wr && cpu_addr[15:13] == 3'b101 && ram_on));

    // R3
    bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_lo != 5'd0);

    // R5
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b011) |=> (mode_adv == $past(cpu_wdata[0])));

    // R6
    low_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_adv && cpu_addr[15:14] == 2'b00) |-> (rom_addr == ROM_A_W'(cpu_addr[13:0])));

    // R12
    other_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15]) |=> ($stable(bank_lo) && $stable(bank_sec) && $stable(mode_adv) && $stable(ram_on)));

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.ROM_A_W(ROM_A_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata),
    .rom_addr  (rom_addr),
    .ram_on    (ram_on),
    .mode_adv  (mode_adv),
    .bank_lo   (bank_lo),
    .bank_sec  (bank_sec)
);

// File: tb/sim_cart_bank_ctrl.sv
`timescale 1ns/1ps
module sim_cart_bank_ctrl;

    localparam int ROM_BANKS = 64;
    localparam int RAM_BANKS = 4;
    localparam int ROM_A_W   = 6 + 14;
    localparam int RAM_A_W   = 2 + 13;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [15:0]        cpu_addr = '0;
    logic [7:0]         cpu_wdata = '0;
    logic               cpu_wr = 1'b0;
    logic               cpu_rd = 1'b0;
    logic [7:0]         ram_rdata = 8'h5C;
    logic               rom_cs, ram_cs, ram_we;
    logic [ROM_A_W-1:0] rom_addr;
    logic [RAM_A_W-1:0] ram_addr;
    logic [7:0]         ram_wdata, cpu_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cart_bank_ctrl #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ram_rdata(ram_rdata),
        .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .cpu_rdata(cpu_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = a; cpu_rd = 1'b1;
        #1;
    endtask

    function automatic logic [31:0] rom_exp(input int mode, input int sec, input int lo,
                                           input logic [15:0] a);
        int lo_eff = (lo == 0) ? 1 : lo;
        int bank;
        if (a[14])       bank = ((sec << 5) | lo_eff) % ROM_BANKS;
        else if (mode)   bank = (sec << 5) % ROM_BANKS;
        else             bank = 0;
        return 32'(bank * 16384 + int'(a[13:0]));
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(16'h4123);
        chk("R1 upper window", 32'(rom_addr), 32'h4123);
        chk("R1 rom_cs", 32'(rom_cs), 1);
        rd(16'h0123);
        chk("R1 low window", 32'(rom_addr), 32'h0123);
        rd(16'hA000);
        chk("R1 ram disabled data", 32'(cpu_rdata), 32'hFF);
        chk("R1 ram_cs low", 32'(ram_cs), 0);

        // R9 R2 enable with 0x0A
        wr(16'h0000, 8'h0A);
        rd(16'hA010);
        chk("R2 enable 0x0A", 32'(ram_cs), 1);
        chk("R9 enabled data", 32'(cpu_rdata), 32'h5C);
        wr(16'h1FFF, 8'h0B);
        rd(16'hA010);
        chk("R2 disable 0x0B", 32'(ram_cs), 0);
        chk("R9 disabled data", 32'(cpu_rdata), 32'hFF);
        wr(16'h1234, 8'hFA);
        rd(16'hBFFF);
        chk("R2 enable upper bits ignored", 32'(cpu_rdata), 32'h5C);

        // R10 write strobe while enabled, and no register effect
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'hA055; cpu_wdata = 8'h00; cpu_wr = 1'b1;
        #1;
        chk("R10 ram_we enabled", 32'(ram_we), 1);
        chk("R10 ram_wdata", 32'(ram_wdata), 32'h00);
        @(negedge clk);
        cpu_wr = 1'b0;
        rd(16'hA000);
        chk("R10 ram write left enable", 32'(cpu_rdata), 32'h5C);
        rd(16'h4000);
        chk("R10 ram write left bank", 32'(rom_addr), 32'h4000);

        // R11 ram address in both modes
        wr(16'h4000, 8'hFE);
        rd(16'hA123);
        chk("R11 simple ram bank 0", 32'(ram_addr), 32'h0123);
        wr(16'h6000, 8'h01);
        rd(16'hB123);
        chk("R11 advanced ram bank", 32'(ram_addr), 32'h5123);
        wr(16'h6000, 8'h00);

        // R10 write blocked while disabled
        wr(16'h0000, 8'h00);
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'hA000; cpu_wdata = 8'h0A; cpu_wr = 1'b1;
        #1;
        chk("R10 ram_we disabled", 32'(ram_we), 0);
        chk("R10 ram_cs disabled", 32'(ram_cs), 0);
        @(negedge clk);
        cpu_wr = 1'b0;

        // R12 writes outside control and RAM windows
        wr(16'h2000, 8'h05);
        wr(16'h4000, 8'h01);
        wr(16'h8000, 8'h0A);
        wr(16'h9FFF, 8'h01);
        wr(16'hC000, 8'h0A);
        wr(16'hFFFF, 8'h03);
        rd(16'h4000);
        chk("R12 bank unchanged", 32'(rom_addr), rom_exp(0, 1, 5, 16'h4000));
        rd(16'h0100);
        chk("R12 mode unchanged", 32'(rom_addr), 32'h0100);
        rd(16'hA000);
        chk("R12 enable unchanged", 32'(cpu_rdata), 32'hFF);

        // R3 R4 R5 R6 R7 R8 sweep
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int d = 0; d < 32; d++) begin
                    logic [15:0] off;
                    off = 16'((d * 517 + s * 91) & 16'h3FFF);
                    wr(16'h6000 | 16'(d), 8'(m) | 8'hA0);
                    wr(16'h4000 | 16'(d << 4), 8'(s) | 8'hF8);
                    wr(16'h2000 | 16'(s << 8), 8'(d) | 8'hA0);
                    rd(16'h4000 | off);
                    chk("R8 R3 R4 upper window", 32'(rom_addr), rom_exp(m, s, d, 16'h4000 | off));
                    rd(off);
                    if (m == 1)
                        chk("R7 R5 advanced low window", 32'(rom_addr), rom_exp(m, s, d, off));
                    else
                        chk("R6 R5 simple low window", 32'(rom_addr), rom_exp(m, s, d, off));
                end
            end
        end

        @(negedge clk);
        cpu_rd = 1'b0;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule